// File: doc/BRIEF.md
# Multi-mode 32-bit timer channel

This block is a single timer channel that sits on a simple memory-mapped register bus. The bus has one-cycle read and write strobes and a byte-enable per lane. The channel holds a compare register and a counter. Two write-only trigger locations start and stop the counter, and a read-only status bit shows whether it is running. A control bit selects one of two modes. In interval mode the counter reloads from the compare value and counts down, and it raises an interrupt every compare+1 clocks. In free-running mode the counter counts up from zero and raises an interrupt whenever it equals the compare value.

Software stops the channel before it reconfigures it, polls the status bit until the stop has taken effect, writes compare and control, and then triggers a start. In free-running mode the counter can be read at any time as a monotonic time base, which also gives one-shot timing against a single compare value. The interrupt output is a registered single-cycle pulse.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter, the compare register and the mode are all 0 (interval mode). The channel is stopped, the interrupt is low and the read data is 0.
- R2: A write with byte lane 0 enabled and data bit 0 set to offset 0x14 starts a stopped channel. From then on, bit 0 of the status word at offset 0x10 reads 1.
- R3: The same kind of write to offset 0x18 stops a running channel at the write edge. The counter then keeps its value, and status bit 0 reads 0.
- R4: Bit 1 of the control byte at offset 0x20 selects the mode: 0 is interval, 1 is free-running. Reads return the mode in bit 1 and 0 in every other bit. A control write made while the channel runs is ignored.
- R5: In interval mode a start loads the counter with the compare value. The counter counts down once per clock and reloads from compare on the clock after it reads 0. The interrupt is high for one clock on the clock after the counter reads 0, so the pulses are compare+1 clocks apart. This holds for compare values from 0xF to 0xFFFFFFFF.
- R6: In free-running mode a start clears the counter to 0, and the counter then increments once per clock and wraps from all ones to 0. The interrupt is high for one clock on the clock after the counter equals compare, and the counter keeps running after a match.
- R7: The compare register at offset 0x00 takes each write byte by byte under the byte enables. Compare reads back at 0x00, and the live counter reads at 0x04.
- R8: A start while running and a stop while stopped have no effect. Reads of 0x14, 0x18 and any unmapped offset return 0.
- R9: Read data is registered. It shows the addressed value one clock after the read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte lane enables for writes |
| bus_rdata | output | DATA_W | Registered read data |
| tmr_irq | output | 1 | Single-cycle interrupt pulse |

## Verification
Start and stop take effect at the edge that samples the trigger write. Read data for a strobe appears after the following edge. An interrupt appears one edge after the counter reaches zero (interval mode) or reaches the compare value (free-running mode). A behavioural model in the bench advances at each rising edge on the same sampled inputs. Every falling edge compares the interrupt and the read data with that model. Directed checks measure pulse spacing from logged edge counts and read the counter a known number of edges after a start. A second instance with an 8-bit counter shares the stimulus, so the wrap in free-running mode can be seen within a short run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Byte offsets that software decodes
  localparam logic [7:0] OFS_CMP   = 8'h00;
  localparam logic [7:0] OFS_CNT   = 8'h04;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_START = 8'h14;
  localparam logic [7:0] OFS_STOP  = 8'h18;
  localparam logic [7:0] OFS_CTL   = 8'h20;

  // Mode select, bit 1 of the control byte
  localparam int CTL_MODE_BIT = 1;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_FREE     = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [DATA_W/8-1:0]   be_i,
  input  logic                  run_i,
  input  logic [CNT_W-1:0]      cnt_i,
  output logic [CNT_W-1:0]      cmp_o,
  output tmr_mode_e             mode_o,
  output logic                  start_o,
  output logic                  stop_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int NB = DATA_W / 8;

  logic              hit_cmp, hit_cnt, hit_stat, hit_start, hit_stop, hit_ctl;
  logic [CNT_W-1:0]  cmp_q;
  tmr_mode_e         mode_q;
  logic [DATA_W-1:0] cmp_next;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign hit_cmp   = addr_i == ADDR_W'(OFS_CMP);
  assign hit_cnt   = addr_i == ADDR_W'(OFS_CNT);
  assign hit_stat  = addr_i == ADDR_W'(OFS_STAT);
  assign hit_start = addr_i == ADDR_W'(OFS_START);
  assign hit_stop  = addr_i == ADDR_W'(OFS_STOP);
  assign hit_ctl   = addr_i == ADDR_W'(OFS_CTL);

  // Trigger strobes: bit 0 of lane 0
  assign start_o = wr_en_i && hit_start && be_i[0] && wdata_i[0];
  assign stop_o  = wr_en_i && hit_stop  && be_i[0] && wdata_i[0];

  // Byte-lane merge for compare writes
  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane
      assign cmp_next[8*b +: 8] = be_i[b] ? wdata_i[8*b +: 8]
                                          : DATA_W'(cmp_q) >> (8*b);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmp_q  <= '0;
      mode_q <= MODE_INTERVAL;
    end else begin
      if (wr_en_i && hit_cmp)
        cmp_q <= cmp_next[CNT_W-1:0];
      if (wr_en_i && hit_ctl && be_i[0] && !run_i)
        mode_q <= tmr_mode_e'(wdata_i[CTL_MODE_BIT]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cmp)       rd_mux = DATA_W'(cmp_q);
    else if (hit_cnt)  rd_mux = DATA_W'(cnt_i);
    else if (hit_stat) rd_mux[0] = run_i;
    else if (hit_ctl)  rd_mux[CTL_MODE_BIT] = (mode_q == MODE_FREE);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign cmp_o   = cmp_q;
  assign mode_o  = mode_q;
  assign rdata_o = rdata_q;

  AST_CTL_LOCKED: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(run_i) |-> $stable(mode_q)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rd_en_i) |-> $stable(rdata_q)); // R9
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             tick, at_zero, at_cmp, fire;

  assign tick    = run_q && !stop_i;
  assign at_zero = cnt_q == '0;
  assign at_cmp  = cnt_q == cmp_i;
  assign fire    = (mode_i == MODE_INTERVAL) ? at_zero : at_cmp;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= tick && fire;
      if (run_q && stop_i) begin
        run_q <= 1'b0;
      end else if (!run_q && start_i) begin
        run_q <= 1'b1;
        cnt_q <= (mode_i == MODE_FREE) ? '0 : cmp_i;
      end else if (tick) begin
        if (mode_i == MODE_FREE) cnt_q <= cnt_q + CNT_W'(1);
        else if (at_zero)        cnt_q <= cmp_i;
        else                     cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_STOPPED_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_q |-> $stable(cnt_q)); // R3
  AST_FREE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && $past(run_q) && mode_i == MODE_FREE)
      |-> cnt_q == $past(cnt_q) + CNT_W'(1)); // R6
  AST_INTERVAL_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && $past(run_q) && mode_i == MODE_INTERVAL && $past(cnt_q) == '0)
      |-> cnt_q == $past(cmp_i)); // R5
  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q |-> $past(run_q)); // R5
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                tmr_irq
);
  logic             run, start, stop;
  logic [CNT_W-1:0] cnt, cmp;
  tmr_mode_e        mode;

  initial begin
    if (CNT_W > DATA_W || DATA_W % 8 != 0)
      $error("tmr_channel: counter must fit the byte-wide data bus");
  end

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk), .rst_i(rst), .wr_en_i(bus_wr), .rd_en_i(bus_rd),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .be_i(bus_be),
    .run_i(run), .cnt_i(cnt), .cmp_o(cmp), .mode_o(mode),
    .start_o(start), .stop_o(stop), .rdata_o(bus_rdata)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk), .rst_i(rst), .start_i(start), .stop_i(stop),
    .mode_i(mode), .cmp_i(cmp), .run_o(run), .cnt_o(cnt), .irq_o(tmr_irq)
  );
endmodule

// File: tb/tmr_channel_tb.sv
`timescale 1ns/1ps
module tmr_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata, n_rdata;
  logic        tmr_irq, n_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_channel u_dut (.clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
                     .bus_be, .bus_rdata, .tmr_irq);
  // 8-bit counter copy on the same stimulus, used to see the wrap
  tmr_channel #(.CNT_W(8)) u_dut_narrow (.clk, .rst, .bus_wr, .bus_rd,
    .bus_addr, .bus_wdata, .bus_be, .bus_rdata(n_rdata), .tmr_irq(n_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit        m_run, m_free, e_irq;
  bit [31:0] m_cnt, m_cmp, e_rdata;

  function automatic bit [31:0] model_read(input bit [5:0] a);
    case (a)
      6'h00: return m_cmp;
      6'h04: return m_cnt;
      6'h10: return {31'b0, m_run};
      6'h20: return {30'b0, m_free, 1'b0};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit st, sp, was_run;
    if (rst) begin
      m_run = 0; m_free = 0; m_cnt = 0; m_cmp = 0; e_irq = 0; e_rdata = 0;
    end else begin
      if (bus_rd) e_rdata = model_read(bus_addr);
      st = bus_wr && bus_addr == 6'h14 && bus_be[0] && bus_wdata[0];
      sp = bus_wr && bus_addr == 6'h18 && bus_be[0] && bus_wdata[0];
      was_run = m_run;
      e_irq = 0;
      if (m_run && !sp) begin
        if (m_free) begin
          if (m_cnt == m_cmp) e_irq = 1;
          m_cnt = m_cnt + 1;
        end else if (m_cnt == 0) begin
          e_irq = 1; m_cnt = m_cmp;
        end else m_cnt = m_cnt - 1;
      end
      if (sp && m_run) m_run = 0;
      else if (st && !m_run) begin
        m_run = 1; m_cnt = m_free ? 32'h0 : m_cmp;
      end
      if (bus_wr && bus_addr == 6'h00)
        for (int b = 0; b < 4; b++)
          if (bus_be[b]) m_cmp[8*b +: 8] = bus_wdata[8*b +: 8];
      if (bus_wr && bus_addr == 6'h20 && bus_be[0] && !was_run)
        m_free = bus_wdata[1];
    end
  end

  // Per-clock comparison and pulse logging
  int cyc = 0, last_t = 0, prev_t = 0, n_pulses = 0;
  int nlast_t = 0, nprev_t = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk(m_free ? "R6 irq vs model" : "R5 irq vs model", {31'b0, tmr_irq}, {31'b0, e_irq});
      chk("R9 rdata vs model", bus_rdata, e_rdata);
    end
    if (tmr_irq) begin prev_t = last_t; last_t = cyc; n_pulses++; end
    if (n_irq)   begin nprev_t = nlast_t; nlast_t = cyc; end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = b;
    @(negedge clk);
    bus_wr = 0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] v, v2;
    int np;
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 irq after reset", {31'b0, tmr_irq}, 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rd(6'h00, v); chk("R1 compare reset", v, 32'h0);
    rd(6'h04, v); chk("R1 counter reset", v, 32'h0);
    rd(6'h10, v); chk("R1 status reset", v, 32'h0);
    rd(6'h20, v); chk("R1 control reset", v, 32'h0);

    // R7 byte-lane writes
    wr(6'h00, 32'h1234_5678, 4'hF);
    wr(6'h00, 32'h0000_AB00, 4'h2);
    rd(6'h00, v); chk("R7 compare byte merge", v, 32'h1234_AB78);

    // R5 interval mode, period 20
    wr(6'h00, 32'd19, 4'hF);
    wr(6'h20, 32'h0, 4'h1);
    wr(6'h14, 32'h1, 4'h1);
    rd(6'h10, v); chk("R2 status after start", v, 32'h1);
    idle(70);
    chk("R5 interval period", last_t - prev_t, 32'd20);
    // R4 control write ignored while running
    wr(6'h20, 32'h2, 4'h1);
    rd(6'h20, v); chk("R4 control locked while running", v, 32'h0);
    // R8 start while running, reads of triggers
    wr(6'h14, 32'h1, 4'h1);
    rd(6'h14, v); chk("R8 start reads 0", v, 32'h0);
    rd(6'h18, v); chk("R8 stop reads 0", v, 32'h0);
    rd(6'h3C, v); chk("R8 unmapped reads 0", v, 32'h0);
    idle(50);
    chk("R8 period kept after extra start", last_t - prev_t, 32'd20);

    // R3 stop freezes
    wr(6'h18, 32'h1, 4'h1);
    rd(6'h10, v); chk("R3 status after stop", v, 32'h0);
    rd(6'h04, v); idle(10); rd(6'h04, v2);
    chk("R3 counter frozen", v2, v);
    wr(6'h18, 32'h1, 4'h1);
    rd(6'h04, v2); chk("R8 stop while stopped", v2, v);
    rd(6'h10, v2); chk("R8 still stopped", v2, 32'h0);

    // R6 free-running mode
    wr(6'h20, 32'h2, 4'h1);
    rd(6'h20, v); chk("R4 control accepted while stopped", v, 32'h2);
    wr(6'h00, 32'd40, 4'hF);
    np = n_pulses;
    wr(6'h14, 32'h1, 4'h1);
    rd(6'h04, v); chk("R6 counter cleared then counting", v, 32'h1);
    idle(600);
    chk("R6 single match, no repeat", n_pulses - np, 32'd1);
    rd(6'h04, v); chk("R6 keeps running past match", {31'b0, v > 32'd600}, 32'h1);
    chk("R6 wrap period on 8-bit counter", nlast_t - nprev_t, 32'd256);

    // R5 minimum compare 0xF
    wr(6'h18, 32'h1, 4'h1);
    wr(6'h20, 32'h0, 4'h1);
    wr(6'h00, 32'h0000_000F, 4'hF);
    wr(6'h14, 32'h1, 4'h1);
    idle(60);
    chk("R5 period at compare 0xF", last_t - prev_t, 32'd16);

    // R5 maximum compare
    wr(6'h18, 32'h1, 4'h1);
    wr(6'h00, 32'hFFFF_FFFF, 4'hF);
    wr(6'h14, 32'h1, 4'h1);
    rd(6'h04, v); chk("R5 full-range load and count down", v, 32'hFFFF_FFFE);
    idle(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule